// File: doc/BRIEF.md
# Capability Dereference Access Checker

This block sits in front of a memory pipeline. It decides whether one access made through a capability may be issued. Each request carries the following inputs:

- the capability fields: a validity tag, a sealed flag, five permission bits, a base, a length and an offset;
- an access kind;
- an access size.

The block forms the effective address as base plus offset. It then checks, in a single step, the tag, the seal state, the permission that the access kind requires, and byte-exact bounds.

One cycle after a valid request, the block returns a response. The response either passes the access or reports exactly one fault cause, picked by a fixed priority. It also reports the effective address. A capability may hold an offset that points outside its region; only an access that actually lands outside the region is refused. Address translation, the memory and exception handling live elsewhere.

Top module: `capAccessCheck`

## Requirements
- R1: A request sampled with `reqValid` high at a rising edge produces `rspValid` high right after that edge. A cycle with `reqValid` low produces `rspValid` low, `rspPass` low and `rspCause` 0 after the next edge.
- R2: A request whose `capTag` is 0 faults with cause code 1, whatever its other fields hold.
- R3: A request with a set tag and `capSealed` 1 faults with cause code 2.
- R4: Each access kind needs one permission bit. The kind codes are 0 instruction fetch, 1 data load, 2 data store, 3 capability load and 4 capability store. The required bit is `capPerms[kind]` for kinds 0 to 4. A missing bit faults with cause code 3. Kind codes 5 to 7 have no permission and always fault with cause code 3.
- R5: `rspAddr` reports base plus offset, taken modulo 2^ADDR_W, for the request just answered. The value holds while no request arrives.
- R6: An access of N bytes at address A is within bounds only if A >= base and A + N <= base + length. Both sums are evaluated without wraparound. Any other access faults with cause code 4.
- R7: For kinds 0 to 2, size codes 0 to 4 mean 1, 2, 4, 8 and 16 bytes. Size codes 5 to 7 are illegal and fault with cause code 4.
- R8: Capability kinds 3 and 4 always access 16 bytes, whatever `accSize` holds.
- R9: Only the highest-priority cause is reported, in the order tag, seal, permission, bounds. `rspPass` is 1 exactly when no cause applies, and in that case `rspCause` is 0.
- R10: While `rstN` is low, `rspValid`, `rspPass`, `rspCause` and `rspAddr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| capTag | input | 1 | Capability validity tag |
| capSealed | input | 1 | Capability is sealed |
| capPerms | input | 5 | Permission bits, indexed by access kind |
| capBase | input | ADDR_W | Region base address |
| capLength | input | ADDR_W | Region length in bytes |
| capOffset | input | ADDR_W | Pointer offset from base |
| accKind | input | 3 | Access kind code |
| accSize | input | 3 | Size code, log2 of bytes |
| rspValid | output | 1 | Response present |
| rspPass | output | 1 | Access may proceed |
| rspCause | output | 3 | Fault cause code, 0 on pass |
| rspAddr | output | ADDR_W | Effective address of the answered request |

## Verification
The bench builds the checker with ADDR_W = 6, so every address lives in a 64-byte space. With that width, a stepped sweep of base, length and offset crosses every size and kind code. The sweep reaches wrapped addresses, regions that end past the top of the space, and accesses that end exactly on the limit. A second sweep covers all 32 permission masks, all eight kind codes and every tag and seal combination, in regions both inside and outside bounds. This sweep shows that only the highest-priority cause is reported.

// File: rtl/capChkPkg.sv
package capChkPkg;
  localparam int PERM_W = 5;
  localparam logic [2:0] SIZE_CODE_MAX = 3'd4;
  localparam logic [2:0] SIZE_CODE_CAP = 3'd4;

  typedef enum logic [2:0] {
    KIND_FETCH  = 3'd0,
    KIND_LOAD   = 3'd1,
    KIND_STORE  = 3'd2,
    KIND_CLOAD  = 3'd3,
    KIND_CSTORE = 3'd4
  } accKindE;

  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_TAG    = 3'd1,
    CAUSE_SEAL   = 3'd2,
    CAUSE_PERM   = 3'd3,
    CAUSE_BOUNDS = 3'd4
  } causeE;

  typedef struct packed {
    logic       loadAddr;
    logic [2:0] sizeCode;
  } ctrlStrobeT;
endpackage

// File: rtl/capChkDatapath.sv
module capChkDatapath
  import capChkPkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [ADDR_W-1:0] capBase,
  input  logic [ADDR_W-1:0] capLength,
  input  logic [ADDR_W-1:0] capOffset,
  output logic              boundsOk,
  output logic [ADDR_W-1:0] rspAddr
);
  localparam int SUM_W = ADDR_W + 1;

  logic [ADDR_W-1:0] effAddr;
  logic [SUM_W-1:0]  sizeBytes;
  logic [SUM_W-1:0]  accEnd;
  logic [SUM_W-1:0]  regionEnd;
  logic              sizeLegal;

  always_comb begin
    effAddr   = capBase + capOffset;
    sizeLegal = strobe.sizeCode <= SIZE_CODE_MAX;
    sizeBytes = SUM_W'(1) << strobe.sizeCode;
    accEnd    = {1'b0, effAddr} + sizeBytes;
    regionEnd = {1'b0, capBase} + {1'b0, capLength};
    boundsOk  = sizeLegal && (effAddr >= capBase) && (accEnd <= regionEnd);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                rspAddr <= '0;
    else if (strobe.loadAddr) rspAddr <= effAddr;
  end

  // R5: captured address is base plus offset of the sampled request
  p_addr_capture_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadAddr |=> rspAddr == $past(capBase + capOffset));
  // R5: address holds without a request
  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadAddr |=> $stable(rspAddr));
endmodule

// File: rtl/capChkControl.sv
module capChkControl
  import capChkPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              capTag,
  input  logic              capSealed,
  input  logic [PERM_W-1:0] capPerms,
  input  logic [2:0]        accKind,
  input  logic [2:0]        accSize,
  input  logic              boundsOk,
  output ctrlStrobeT        strobe,
  output logic              rspValid,
  output logic              rspPass,
  output logic [2:0]        rspCause
);
  logic  capKind;
  logic  permOk;
  causeE nextCause;

  always_comb begin
    capKind = (accKind == KIND_CLOAD) || (accKind == KIND_CSTORE);
    strobe.loadAddr = reqValid;
    strobe.sizeCode = capKind ? SIZE_CODE_CAP : accSize;
    permOk = 1'b0;
    for (int k = 0; k < PERM_W; k++)
      if (accKind == 3'(k)) permOk = capPerms[k];
  end

  always_comb begin
    if (!capTag)         nextCause = CAUSE_TAG;
    else if (capSealed)  nextCause = CAUSE_SEAL;
    else if (!permOk)    nextCause = CAUSE_PERM;
    else if (!boundsOk)  nextCause = CAUSE_BOUNDS;
    else                 nextCause = CAUSE_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !reqValid) begin
      rspValid <= 1'b0;
      rspPass  <= 1'b0;
      rspCause <= CAUSE_NONE;
    end else begin
      rspValid <= 1'b1;
      rspPass  <= (nextCause == CAUSE_NONE);
      rspCause <= nextCause;
    end
  end

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && !rspPass && rspCause == 3'd0));
  p_tag_first_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !capTag) |=> rspCause == 3'd1);
  p_seal_second_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && capTag && capSealed) |=> rspCause == 3'd2);
  p_pass_clean_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspPass |-> (rspValid && rspCause == 3'd0));
  p_fault_named_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspPass) |-> rspCause != 3'd0);
endmodule

// File: rtl/capAccessCheck.sv
module capAccessCheck
  import capChkPkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              capTag,
  input  logic              capSealed,
  input  logic [4:0]        capPerms,
  input  logic [ADDR_W-1:0] capBase,
  input  logic [ADDR_W-1:0] capLength,
  input  logic [ADDR_W-1:0] capOffset,
  input  logic [2:0]        accKind,
  input  logic [2:0]        accSize,
  output logic              rspValid,
  output logic              rspPass,
  output logic [2:0]        rspCause,
  output logic [ADDR_W-1:0] rspAddr
);
  ctrlStrobeT strobe;
  logic       boundsOk;

  capChkControl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .capTag(capTag),
    .capSealed(capSealed), .capPerms(capPerms), .accKind(accKind),
    .accSize(accSize), .boundsOk(boundsOk), .strobe(strobe),
    .rspValid(rspValid), .rspPass(rspPass), .rspCause(rspCause)
  );

  capChkDatapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .capBase(capBase),
    .capLength(capLength), .capOffset(capOffset), .boundsOk(boundsOk),
    .rspAddr(rspAddr)
  );

  // R10: reset clears every response field on the following edge
  p_reset_clear_r10: assert property (@(posedge clk)
    !rstN |=> (!rspValid && !rspPass && rspCause == 3'd0 && rspAddr == '0));
endmodule

// File: tb/capAccessCheck_tb.sv
module capAccessCheck_tb;
  localparam int AW = 6;
  localparam int SPACE = 1 << AW;

  logic clk = 0;
  logic rstN = 0;
  logic reqValid = 0, capTag = 0, capSealed = 0;
  logic [4:0] capPerms = 0;
  logic [AW-1:0] capBase = 0, capLength = 0, capOffset = 0;
  logic [2:0] accKind = 0, accSize = 0;
  logic rspValid, rspPass;
  logic [2:0] rspCause;
  logic [AW-1:0] rspAddr;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  capAccessCheck #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .capTag(capTag),
    .capSealed(capSealed), .capPerms(capPerms), .capBase(capBase),
    .capLength(capLength), .capOffset(capOffset), .accKind(accKind),
    .accSize(accSize), .rspValid(rspValid), .rspPass(rspPass),
    .rspCause(rspCause), .rspAddr(rspAddr)
  );

  function automatic int expCause(bit tag, bit sealed, bit [4:0] perms,
                                  int kind, int size, int base, int len, int off);
    int bytes, addr;
    bit isCap;
    if (!tag) return 1;
    if (sealed) return 2;
    if (kind > 4) return 3;
    if (!perms[kind]) return 3;
    isCap = (kind == 3) || (kind == 4);
    if (!isCap && size > 4) return 4;          // R7 illegal size codes
    bytes = isCap ? 16 : (1 << size);          // R8 capability accesses are 16 bytes
    addr = (base + off) % SPACE;
    if (addr < base || addr + bytes > base + len) return 4;
    return 0;
  endfunction

  function automatic string tagFor(int c);
    case (c)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic runReq(bit tag, bit sealed, bit [4:0] perms, int kind, int size,
                        int base, int len, int off);
    int ec, ea;
    reqValid = 1; capTag = tag; capSealed = sealed; capPerms = perms;
    accKind = 3'(kind); accSize = 3'(size);
    capBase = AW'(base); capLength = AW'(len); capOffset = AW'(off);
    @(negedge clk);
    ec = expCause(tag, sealed, perms, kind, size, base, len, off);
    ea = (base + off) % SPACE;
    checks++;
    if (rspValid !== 1'b1 || rspPass !== (ec == 0) || int'(rspCause) != ec) begin
      fails++;
      $display("FAIL %s/R1/R9 kind=%0d size=%0d b=%0d l=%0d o=%0d: valid=%0b pass=%0b cause=%0d expected valid=1 pass=%0b cause=%0d",
               tagFor(ec), kind, size, base, len, off, rspValid, rspPass, rspCause, ec == 0, ec);
    end
    checks++;
    if (int'(rspAddr) != ea) begin
      fails++;
      $display("FAIL R5 addr: got %0d expected %0d", rspAddr, ea);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    checks++;
    if (rspValid !== 0 || rspPass !== 0 || rspCause !== 0 || rspAddr !== 0) begin
      fails++;
      $display("FAIL R10 reset: got v=%0b p=%0b c=%0d a=%0d expected all 0",
               rspValid, rspPass, rspCause, rspAddr);
    end
    rstN = 1;
    @(negedge clk);

    // R6 R7 R8 geometry sweep with a valid, unsealed, fully permitted capability
    for (int b = 0; b < SPACE; b += 7)
      for (int l = 0; l < SPACE; l += 9)
        for (int o = 0; o < SPACE; o += 5)
          for (int k = 0; k < 5; k++)
            for (int s = 0; s < 8; s++)
              runReq(1, 0, 5'h1f, k, s, b, l, o);

    // exact-limit cases for R6: end on the limit passes, one past faults
    runReq(1, 0, 5'h1f, 1, 2, 10, 8, 4);
    runReq(1, 0, 5'h1f, 1, 2, 10, 8, 5);
    runReq(1, 0, 5'h1f, 3, 0, 32, 16, 0);
    runReq(1, 0, 5'h1f, 4, 0, 32, 15, 0);

    // R2 R3 R4 R9 priority sweep
    for (int t = 0; t < 2; t++)
      for (int sl = 0; sl < 2; sl++)
        for (int p = 0; p < 32; p++)
          for (int k = 0; k < 8; k++) begin
            runReq(t[0], sl[0], 5'(p), k, 2, 8, 40, 4);
            runReq(t[0], sl[0], 5'(p), k, 2, 40, 4, 10);
          end

    // R1 idle response after the last request
    reqValid = 0;
    @(negedge clk);
    checks++;
    if (rspValid !== 0 || rspPass !== 0 || rspCause !== 0) begin
      fails++;
      $display("FAIL R1 idle: got v=%0b p=%0b c=%0d expected 0 0 0", rspValid, rspPass, rspCause);
    end
    // R5 address holds while idle (last request: base 40 + offset 10)
    checks++;
    if (int'(rspAddr) != 50) begin
      fails++;
      $display("FAIL R5 hold: got %0d expected 50", rspAddr);
    end

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule